// File: doc/BRIEF.md
# Calendar Real-Time Clock Core

This core keeps wall-clock time and the calendar. It holds seconds, minutes, hours, a day-of-week, the day of the month, the month and a two-digit year. A free-running prescaler divides the system clock down to one advance per second. When that advance arrives, every carry through the fields resolves in the same clock cycle, so a 23:59:59 rollover moves the hour, the day of the month, the month, the year and the day-of-week together. Month lengths follow the calendar. February has 29 days in any year whose value is a multiple of 4, and year 00 is one of those.

Software reaches the core through a small register bus. A read returns any field at once. A write to a field takes effect only if the bus write just before it went to the unlock register, so every field write needs its own unlock. Software can also restart the prescaler, which begins a full second from that point. System reset clears the prescaler and the unlock state, and it leaves the time untouched. The time fields have no reset, so they hold no defined value until software sets them.

Top module: `rtc_calendar`

## Requirements
- R1: Seconds and minutes count 0 to 59 and hours count 0 to 23, with 0 meaning midnight. A second tick on 59 seconds sets seconds to 0 and advances minutes. All carries settle in the same clock edge.
- R2: Day-of-week counts 1 to 7, where 1 means Sunday. It steps from 7 back to 1, and it advances only when the day of the month advances, at 23:59:59.
- R3: The day of the month runs from 1 up to the length of the current month, which is 30 for months 4, 6, 9 and 11, 31 for the other months and variable for February. Month runs 1 to 12. Year runs 0 to 99 and steps from 99 back to 0.
- R4: When the year value is a multiple of 4, including 0, February has 29 days. In every other year it has 28.
- R5: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 day-of-week, 4 day of month, 5 month, 6 year, 7 unlock and 8 control. A write to addresses 0 to 6 is accepted only if the bus write directly before it went to address 7, with any data. Otherwise the write is dropped. Repeated unlock writes keep the core unlocked.
- R6: Any bus write to an address other than 7 removes the unlock. This holds whether the write was accepted or dropped, and it includes control writes and writes to unmapped addresses.
- R7: A write of 1 in bit 0 of the control register, address 8, clears the prescaler. The next second tick then arrives PRESCALE_DIV clock cycles after that write's edge. Control writes need no unlock.
- R8: Without writes, the time advances by exactly one second every PRESCALE_DIV clock cycles, and it stays unchanged in between.
- R9: Synchronous reset clears the prescaler and the unlock state. It leaves every time field unchanged.
- R10: A field stores the low bits of the written data as written, even when the value is out of range. The field widths are 6 bits for seconds and minutes, 5 bits for hours and the day of the month, 3 bits for day-of-week, 4 bits for month and 7 bits for year. When the field next increments, any value at or above its maximum returns to the minimum and carries on.
- R11: A read returns the field at bus_addr in the low bits of bus_rdata, with the upper bits zero, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of prescaler and unlock state |
| bus_wr | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 4 | Register address for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
Calendar rollovers are hard to reach from the ports. A real prescaler needs months of ticks to reach a month end, a leap February or the year 99 wrap. The bench therefore shrinks PRESCALE_DIV. It restarts the prescaler and loads a time one second before each boundary through unlocked writes. A second restart then pins the tick to a known cycle. The bench checks the time one cycle before that tick and again just after it. The unlock rules are reached the same way, with dropped writes interleaved between the restart and the next tick so that no second advance can hide them.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_SEC   = 4'd0,
        A_MIN   = 4'd1,
        A_HOUR  = 4'd2,
        A_DOW   = 4'd3,
        A_DATE  = 4'd4,
        A_MONTH = 4'd5,
        A_YEAR  = 4'd6,
        A_WREN  = 4'd7,
        A_CTRL  = 4'd8
    } reg_addr_e;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [2:0] DOW_LAST  = 3'd7;
    localparam logic [3:0] MON_LAST  = 4'd12;
    localparam logic [6:0] YEAR_LAST = 7'd99;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] month;
        logic [4:0] date;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_time_t;

    typedef struct packed {
        logic              valid;
        reg_addr_e         sel;
        logic [DATA_W-1:0] data;
    } field_wr_t;

    function automatic logic is_leap(input logic [6:0] yr);
        return (yr[1:0] == 2'b00);
    endfunction

    function automatic logic [4:0] month_len(input logic [3:0] mon, input logic [6:0] yr);
        logic [4:0] len;
        case (mon)
            4'd2:                       len = is_leap(yr) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:    len = 5'd30;
            default:                    len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_bus_ctrl.sv
`timescale 1ns/1ps
module rtc_bus_ctrl
    import rtc_cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              armed,
    output field_wr_t         fwr,
    output logic              restart
);

    logic armed_q;
    logic is_field;

    assign is_field = (addr <= ADDR_W'(A_YEAR));

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (wr) begin
            armed_q <= (addr == ADDR_W'(A_WREN));
        end
    end

    always_comb begin
        fwr.valid = wr && armed_q && is_field;
        fwr.sel   = reg_addr_e'(addr);
        fwr.data  = wdata;
    end

    assign restart = wr && (addr == ADDR_W'(A_CTRL)) && wdata[0];
    assign armed   = armed_q;

endmodule

// File: rtl/rtc_prescaler.sv
`timescale 1ns/1ps
module rtc_prescaler #(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);

    localparam int CW = (PRESCALE_DIV > 2) ? $clog2(PRESCALE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE_DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          at_last;

    assign at_last = (cnt_q == LAST);
    assign tick    = at_last && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/rtc_time_counter.sv
`timescale 1ns/1ps
module rtc_time_counter
    import rtc_cal_pkg::*;
(
    input  logic      clk,
    input  logic      tick,
    input  field_wr_t fwr,
    output cal_time_t tm
);

    cal_time_t tm_q;
    cal_time_t nxt;

    always_comb begin
        logic c_sec, c_min, c_hour, c_date, c_mon;
        nxt    = tm_q;
        c_sec  = 1'b0;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_date = 1'b0;
        c_mon  = 1'b0;
        if (fwr.valid) begin
            case (fwr.sel)
                A_SEC:   nxt.sec   = fwr.data[5:0];
                A_MIN:   nxt.min   = fwr.data[5:0];
                A_HOUR:  nxt.hour  = fwr.data[4:0];
                A_DOW:   nxt.dow   = fwr.data[2:0];
                A_DATE:  nxt.date  = fwr.data[4:0];
                A_MONTH: nxt.month = fwr.data[3:0];
                A_YEAR:  nxt.year  = fwr.data[6:0];
                default: nxt       = tm_q;
            endcase
        end else if (tick) begin
            c_sec   = (tm_q.sec >= SEC_LAST);
            nxt.sec = c_sec ? 6'd0 : tm_q.sec + 6'd1;
            if (c_sec) begin
                c_min   = (tm_q.min >= MIN_LAST);
                nxt.min = c_min ? 6'd0 : tm_q.min + 6'd1;
            end
            if (c_min) begin
                c_hour   = (tm_q.hour >= HOUR_LAST);
                nxt.hour = c_hour ? 5'd0 : tm_q.hour + 5'd1;
            end
            if (c_hour) begin
                nxt.dow  = (tm_q.dow >= DOW_LAST) ? 3'd1 : tm_q.dow + 3'd1;
                c_date   = (tm_q.date >= month_len(tm_q.month, tm_q.year));
                nxt.date = c_date ? 5'd1 : tm_q.date + 5'd1;
            end
            if (c_date) begin
                c_mon     = (tm_q.month >= MON_LAST);
                nxt.month = c_mon ? 4'd1 : tm_q.month + 4'd1;
            end
            if (c_mon) begin
                nxt.year = (tm_q.year >= YEAR_LAST) ? 7'd0 : tm_q.year + 7'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        tm_q <= nxt;
    end

    assign tm = tm_q;

endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_cal_pkg::*;
#(
    parameter int PRESCALE_DIV = 32768
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    logic      armed;
    logic      restart;
    logic      tick;
    field_wr_t fwr;
    cal_time_t tm_q;

    rtc_bus_ctrl u_bus (
        .clk     (clk),
        .rst     (rst),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .armed   (armed),
        .fwr     (fwr),
        .restart (restart)
    );

    rtc_prescaler #(
        .PRESCALE_DIV (PRESCALE_DIV)
    ) u_presc (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    rtc_time_counter u_time (
        .clk  (clk),
        .tick (tick),
        .fwr  (fwr),
        .tm   (tm_q)
    );

    always_comb begin
        case (bus_addr)
            ADDR_W'(A_SEC):   bus_rdata = DATA_W'(tm_q.sec);
            ADDR_W'(A_MIN):   bus_rdata = DATA_W'(tm_q.min);
            ADDR_W'(A_HOUR):  bus_rdata = DATA_W'(tm_q.hour);
            ADDR_W'(A_DOW):   bus_rdata = DATA_W'(tm_q.dow);
            ADDR_W'(A_DATE):  bus_rdata = DATA_W'(tm_q.date);
            ADDR_W'(A_MONTH): bus_rdata = DATA_W'(tm_q.month);
            ADDR_W'(A_YEAR):  bus_rdata = DATA_W'(tm_q.year);
            default:          bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_calendar_chk.sv
`timescale 1ns/1ps
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              restart_bit,
    input logic              armed,
    input logic              tick,
    input cal_time_t         tm
);

    // R6: any non-unlock write drops the unlock
    assert_arm_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != ADDR_W'(A_WREN)) |=> !armed);

    // R5: an unlock write arms the next write
    assert_arm_set_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(A_WREN)) |=> armed);

    // R5: unarmed seconds write leaves seconds alone
    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(A_SEC) && !armed && !tick) |=> $stable(tm.sec));

    // R7: restart begins a full second, so no tick right after it
    assert_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(A_CTRL) && restart_bit) |=> !tick);

    // R1: seconds wrap at the top of the range
    assert_sec_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && tm.sec >= SEC_LAST) |=> (tm.sec == 6'd0));

    // R8: one second per tick
    assert_sec_step_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && tm.sec < SEC_LAST) |=> (tm.sec == $past(tm.sec) + 6'd1));

    // R8: time holds between ticks
    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !bus_wr) |=> $stable(tm));

    // R2: day-of-week lands in 1..7 after a day rollover
    assert_dow_range_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !bus_wr && tm.sec >= SEC_LAST && tm.min >= MIN_LAST && tm.hour >= HOUR_LAST)
        |=> (tm.dow >= 3'd1 && tm.dow <= DOW_LAST));

endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .restart_bit (bus_wdata[0]),
    .armed       (armed),
    .tick        (tick),
    .tm          (tm_q)
);

// File: tb/tb_rtc_calendar.sv
`timescale 1ns/1ps
module tb_rtc_calendar;
    import rtc_cal_pkg::*;

    localparam int DIV = 64;
    localparam int NV  = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = 4'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    rtc_calendar #(.PRESCALE_DIV(DIV)) dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    // sec,min,hour,dow,date,month,year -> expected after one tick
    localparam int VEC [NV][14] = '{
        '{ 0, 0, 0,1, 1, 1,23,   1, 0, 0,1, 1, 1,23},
        '{59,34,12,3,15, 6,40,   0,35,12,3,15, 6,40},
        '{59,59,13,3,15, 6,40,   0, 0,14,3,15, 6,40},
        '{59,59,23,7,31, 1,23,   0, 0, 0,1, 1, 2,23},
        '{59,59,23,3,28, 2,23,   0, 0, 0,4, 1, 3,23},
        '{59,59,23,3,28, 2,24,   0, 0, 0,4,29, 2,24},
        '{59,59,23,4,29, 2,24,   0, 0, 0,5, 1, 3,24},
        '{59,59,23,1,28, 2, 0,   0, 0, 0,2,29, 2, 0},
        '{59,59,23,2,30, 4,50,   0, 0, 0,3, 1, 5,50},
        '{59,59,23,5,31,12,99,   0, 0, 0,6, 1, 1, 0},
        '{59,59,23,1,30, 7,10,   0, 0, 0,2,31, 7,10},
        '{63,10, 5,2,10, 3, 5,   0,11, 5,2,10, 3, 5},
        '{59,59,25,2,10, 3, 5,   0, 0, 0,3,11, 3, 5},
        '{59,59,23,6,31,13, 5,   0, 0, 0,7, 1, 1, 6},
        '{59,59,23,0,10, 3, 5,   0, 0, 0,1,11, 3, 5},
        '{59,59,23,2,31, 4, 8,   0, 0, 0,3, 1, 5, 8}
    };

    localparam string VTAG [NV] = '{
        "R1 second step", "R1 minute carry", "R1 hour carry",
        "R2 R3 january end dow wrap", "R4 february 28 common year",
        "R4 february 28 leap year", "R4 february 29 leap end",
        "R4 year 00 leap", "R3 april end", "R3 year 99 wrap",
        "R3 july 30 not end", "R10 seconds 63", "R10 hour 25",
        "R10 month 13", "R10 dow 0", "R10 date 31 in april"
    };

    function automatic string fname(input int f);
        case (f)
            0: return "sec";
            1: return "min";
            2: return "hour";
            3: return "dow";
            4: return "date";
            5: return "month";
            default: return "year";
        endcase
    endfunction

    task automatic check_eq(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic bus_write(input int a, input int d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 4'(a);
        bus_wdata = 8'(d);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic read_field(input int a, output int v);
        bus_addr = 4'(a);
        #0.4;
        v = int'(bus_rdata);
    endtask

    task automatic check_field(input string tag, input int a, input int exp);
        int v;
        read_field(a, v);
        check_eq(tag, fname(a), v, exp);
    endtask

    task automatic check_vec(input int idx, input int off, input string tag);
        for (int f = 0; f < 7; f++) begin
            check_field(tag, f, VEC[idx][off + f]);
        end
    endtask

    task automatic load_time(input int idx);
        for (int f = 0; f < 7; f++) begin
            bus_write(int'(A_WREN), 0);
            bus_write(f, VEC[idx][f]);
        end
    endtask

    task automatic restart_second();
        bus_write(int'(A_CTRL), 1);
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Table walk: R1 R2 R3 R4 R8 R10 rollovers
        for (int i = 0; i < NV; i++) begin
            restart_second();
            load_time(i);
            restart_second();
            repeat (DIV - 1) @(negedge clk);
            check_vec(i, 0, "R8 held before tick");
            @(negedge clk);
            check_vec(i, 7, VTAG[i]);
        end

        // Unlock rules R5 R6 plus write truncation R10 and read map R11
        restart_second();
        load_time(0);
        restart_second();
        bus_write(int'(A_MIN), 20);
        check_field("R5 unarmed write ignored", int'(A_MIN), 0);
        bus_write(int'(A_WREN), 0);
        bus_write(int'(A_SEC), 10);
        check_field("R5 armed write accepted", int'(A_SEC), 10);
        bus_write(int'(A_MIN), 21);
        check_field("R6 arm cleared by accepted write", int'(A_MIN), 0);
        bus_write(int'(A_WREN), 0);
        bus_write(int'(A_CTRL), 0);
        bus_write(int'(A_HOUR), 5);
        check_field("R6 arm cleared by control write", int'(A_HOUR), 0);
        bus_write(int'(A_WREN), 0);
        bus_write(9, 0);
        bus_write(int'(A_HOUR), 6);
        check_field("R6 arm cleared by unmapped write", int'(A_HOUR), 0);
        bus_write(int'(A_WREN), 0);
        bus_write(int'(A_WREN), 0);
        bus_write(int'(A_DOW), 5);
        check_field("R5 repeated unlock", int'(A_DOW), 5);
        bus_write(int'(A_WREN), 0);
        bus_write(int'(A_SEC), 8'hFF);
        check_field("R10 truncated to field width", int'(A_SEC), 63);
        check_field("R11 unlock register reads zero", int'(A_WREN), 0);

        // R7: a restart mid-second pushes the next tick out
        restart_second();
        load_time(0);
        restart_second();
        repeat (30) @(negedge clk);
        restart_second();
        repeat (DIV - 1) @(negedge clk);
        check_field("R7 restart delays tick", int'(A_SEC), 0);
        @(negedge clk);
        check_field("R7 tick one second after restart", int'(A_SEC), 1);

        // R9: reset keeps time, clears prescaler and unlock
        restart_second();
        load_time(1);
        restart_second();
        repeat (20) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check_vec(1, 0, "R9 fields kept through reset");
        repeat (DIV - 1) @(negedge clk);
        check_field("R9 prescaler cleared by reset", int'(A_SEC), 59);
        @(negedge clk);
        check_vec(1, 7, "R9 tick one second after reset");
        bus_write(int'(A_WREN), 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        bus_write(int'(A_SEC), 3);
        check_field("R9 reset clears unlock", int'(A_SEC), 0);

        done = 1'b1;
        report();
    end

endmodule